// File: doc/BRIEF.md
# Bit-Serial Lookup FIR Filter

This block is a constant-coefficient FIR filter that uses no multipliers. It keeps the most recent N input samples in a shift register. The coefficients are fixed when the design is elaborated, and from them every possible subset sum is built into a table of 2^N entries. Each output takes one cycle per bit of the input word. In each of those cycles the same bit position is taken from all N stored samples. Those N bits form the table address, and the table value is folded into an accumulator that shifts right by one place each cycle. Bits are visited from the least significant upward. The term for the sign bit is subtracted, so the stored samples are weighted as two's complement numbers.

A new sample is taken on an input strobe when the ready flag is high. The filtered result comes out with a one-cycle valid pulse and is held until the next result. One output takes B cycles for a B-bit sample, however many taps there are. The final bit cycle of one frame can also accept the next sample, so a source that keeps its strobe high gets one output every B cycles.

Top module: `da_fir`

## Requirements
- R1: While reset is low and in the first cycle after it is released, in_ready is 1, out_valid is 0, out_data is 0 and every stored sample is zero.
- R2: A sample is taken when in_valid and in_ready are both high at a rising edge. in_ready is high only when no frame is running, or in the final bit cycle of a frame. In every other cycle of a frame it is low.
- R3: Each accepted sample produces exactly one out_valid pulse, one cycle long. The pulse is high in the cycle after the B-th rising edge that follows the accepting edge.
- R4: out_data is the exact two's complement value of sum over k of c[k]·x[n-k], where x[n] is the newest accepted sample. Coefficient k sits in bits [k·CW +: CW] of COEFS. The result is sign-extended to the output width with no truncation or rounding.
- R5: Stored samples that have not yet been filled since reset count as zero, so the first N-1 outputs use only the samples accepted so far.
- R6: If a new sample is offered in every cycle where in_ready is high, outputs come out exactly B cycles apart.
- R7: An in_valid pulse while in_ready is low is ignored. Its data never reaches the delay line or any later output.
- R8: out_data keeps its value in every cycle where out_valid is low.
- R9: The most negative input value and the most negative coefficient give exact results, because the sign-bit table term is subtracted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | BW | Signed input sample |
| in_ready | output | 1 | High when a sample can be taken this cycle |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_data | output | OUT_W | Signed filter result, held between pulses |

## Verification
Two events can fall on the same clock edge: a new sample is taken, and the previous frame ends and its result is registered. At that edge the delay line shifts while its old contents still form the table address for the final subtracted sign term. The bench provokes this by running a sweep of every input value in which the strobe stays high. Each result is compared with a direct convolution computed in the bench, and the gap between pulses must be exactly B cycles. Separate runs with idle gaps, junk strobes sent mid-frame, and extreme values show that a new sample arriving never corrupts the frame that is ending.

// File: rtl/da_fir.sv
module da_fir #(
  parameter int NTAPS = 4,
  parameter int BW = 8,
  parameter int CW = 8,
  parameter logic [NTAPS*CW-1:0] COEFS = {8'sd17, -8'sd128, 8'sd100, -8'sd3},
  localparam int TW = CW + $clog2(NTAPS) + 1,
  localparam int HW = TW + 1,
  localparam int OUT_W = HW + BW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [BW-1:0]    in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);
  localparam int DEPTH = 1 << NTAPS;
  localparam int CNT_W = (BW > 2) ? $clog2(BW) : 1;

  function automatic logic signed [TW-1:0] entry_f(input int a);
    logic signed [TW-1:0] s;
    s = '0;
    for (int k = 0; k < NTAPS; k++)
      if (a[k]) s = s + {{(TW-CW){COEFS[k*CW+CW-1]}}, COEFS[k*CW +: CW]};
    return s;
  endfunction

  logic signed [TW-1:0] tbl [DEPTH];
  for (genvar a = 0; a < DEPTH; a++) begin : g_tbl
    localparam logic signed [TW-1:0] V = entry_f(a);
    assign tbl[a] = V;
  end

  logic [BW-1:0]    taps [NTAPS];
  logic [CNT_W-1:0] cnt;
  logic             busy;
  logic [OUT_W-1:0] acc;
  logic [NTAPS-1:0] addr;

  // R2: ready when idle or in the final bit cycle of a frame
  wire first  = busy && (cnt == '0);
  wire last   = busy && (cnt == CNT_W'(BW-1));
  wire accept = in_valid && in_ready;
  assign in_ready = !busy || last;

  always_comb
    for (int k = 0; k < NTAPS; k++) addr[k] = taps[k][cnt];

  wire signed [HW:0]   term = HW'(tbl[addr]);
  wire signed [HW-1:0] hi   = first ? '0 : acc[OUT_W-1:BW];
  // R9: sign-bit term carries negative weight
  wire signed [HW:0]   sum  = last ? (hi - term) : (hi + term);
  wire [BW-2:0]        lo   = first ? '0 : acc[BW-1:1];
  wire [OUT_W-1:0]     acc_nxt = {sum, lo};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      acc  <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      for (int k = 0; k < NTAPS; k++) taps[k] <= '0;
    end else begin
      out_valid <= last;
      if (last) out_data <= acc_nxt;
      if (busy) acc <= acc_nxt;
      if (accept) begin
        busy <= 1'b1;
        cnt  <= '0;
        taps[0] <= in_data;
        for (int k = 1; k < NTAPS; k++) taps[k] <= taps[k-1];
      end else if (last) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

module da_fir_chk #(
  parameter int OUT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data
);
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));
  a_r6_ready_before_out: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_ready));
endmodule

bind da_fir da_fir_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/da_fir_bench.sv
module da_fir_bench;
  localparam int BW = 8;
  localparam int OUT_W = 8 + 2 + 2 + BW;

  logic clk = 1'b0;
  logic rst_n, in_valid, in_ready, out_valid;
  logic [BW-1:0] in_data;
  logic [OUT_W-1:0] out_data;

  da_fir #(.NTAPS(4), .BW(BW), .CW(8),
           .COEFS({8'sd17, -8'sd128, 8'sd100, -8'sd3})) u_da_fir (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data));

  always #4 clk = ~clk;

  int coefs [4] = '{-3, 100, -128, 17};
  int hist [4] = '{0, 0, 0, 0};
  longint exp_q [$];
  int cyc_q [$];
  string tag_q [$];
  string tag = "R5";
  string prev_tag = "";
  int cyc = 0, n_chk = 0, n_fail = 0, last_out = -1;
  longint last_val = 0;
  bit started = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic send(input int x, input bit junk);
    longint e;
    forever begin
      @(negedge clk);
      in_valid = 1'b0;
      if (in_ready) break;
      if (junk) begin in_valid = 1'b1; in_data = 8'h5A ^ 8'(cyc); end
    end
    in_valid = 1'b1;
    in_data = x[BW-1:0];
    for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    e = 0;
    for (int k = 0; k < 4; k++) e += longint'(coefs[k]) * hist[k];
    exp_q.push_back(e);
    cyc_q.push_back(cyc + 1);
    tag_q.push_back(tag);
  endtask

  task automatic send_gap(input int x);
    send(x, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R2", in_ready, 0);
    repeat (BW + 2) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && started) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3", 1, 0);
        end else begin
          longint e;
          int c;
          string t;
          e = exp_q.pop_front();
          c = cyc_q.pop_front();
          t = tag_q.pop_front();
          chk(longint'($signed(out_data)) == e, t, longint'($signed(out_data)), e);
          chk(cyc - c == BW, "R3", cyc - c, BW);
          if (t == "R6" && prev_tag == "R6")
            chk(cyc - last_out == BW, "R6", cyc - last_out, BW);
          prev_tag = t;
        end
        last_out = cyc;
        last_val = longint'($signed(out_data));
      end else begin
        chk(longint'($signed(out_data)) == last_val, "R8", longint'($signed(out_data)), last_val);
      end
    end
  end

  initial begin
    #(8 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", in_ready, 1);
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    chk(out_data == '0, "R1", longint'($signed(out_data)), 0);
    started = 1;

    // R5: impulse through a zero-filled delay line
    tag = "R5";
    send_gap(1);
    repeat (3) send_gap(0);

    // R9: extreme values
    tag = "R9";
    repeat (4) send_gap(-128);
    send_gap(127);
    send_gap(-128);
    send_gap(-1);

    // R7: junk strobes mid-frame
    tag = "R7";
    send(50, 1'b0);
    send(-77, 1'b1);
    send(33, 1'b1);
    send(-128, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (BW + 2) @(negedge clk);

    // R4: gapped assorted values
    tag = "R4";
    send_gap(5);
    send_gap(-9);
    send_gap(64);
    send_gap(-100);

    // R6: full back-to-back sweep of every input code
    tag = "R6";
    for (int v = -128; v < 128; v++) send(v, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (BW + 4) @(negedge clk);
    chk(exp_q.size() == 0, "R3", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule